// File: doc/BRIEF.md
# Scan Test Authorization Controller

This block stands between the test-mode pin of a cipher core and the scan infrastructure around it. It watches the test-mode input and drives four controls: an isolation enable that cuts the cipher key off from the scan chains, a one-cycle clear pulse for the sensitive registers, a gate that permits scan shifting, and a flag that tells the rest of the chip whether unrestricted scan testing is allowed.

Each entry into test mode begins with a clear pulse and then opens a bounded authorization window. During the window the tester shifts a serial password into the block, one bit per strobed cycle, and the block compares it against a secret fixed at build time. It records only whether any bit has differed. When the whole password matches before the window closes, full scan is granted. A wrong password or a window that runs out leaves the session in restricted scan, with the key still isolated, until test mode is dropped. Every return to functional mode also passes through a clear pulse, so values loaded by scan never reach normal operation.

Top module: `scan_auth_ctrl`

## Requirements
- R1: While `rst_n` is low the block is held in functional mode. After reset, with `test_mode_i` low, all four outputs are 0.
- R2: In the cycle after `test_mode_i` is first seen high in functional mode, `sens_clr_o` is 1 for exactly one cycle. `scan_en_o` is 0 in that cycle and in the following cycle, which is the first cycle of the authorization window.
- R3: Whenever `test_mode_i` is 1 and full test has not been granted, `key_iso_o` is 1. This includes the same cycle in which `test_mode_i` rises.
- R4: The password is `KEY_W` bits long (default 128), most significant bit first. A bit is taken on each clock edge at which `auth_vld_i` is 1 during the window. The window opens in the cycle after the clear pulse and lasts `WINDOW` cycles (default 128).
- R5: If all `KEY_W` bits match the secret and the last bit is taken inside the window, then from the next cycle `full_test_o` is 1, `key_iso_o` is 0 and `scan_en_o` is 1.
- R6: If any taken bit differs from the secret, the session ends in restricted mode after the last bit: `full_test_o` is 0, `key_iso_o` is 1 and `scan_en_o` is 1.
- R7: When the window closes before all bits have arrived, the session enters restricted mode, and bits strobed afterwards are ignored. A last bit taken on the final cycle of the window still counts as in time.
- R8: Restricted mode is locked for the rest of the session. A correct password sent afterwards leaves `full_test_o` at 0.
- R9: When `test_mode_i` falls in any test state, `sens_clr_o` pulses for one cycle with `key_iso_o` high. In the cycle after that, the block is functional with all outputs 0.
- R10: Leaving test mode during the window discards any bits already taken. The next session starts a fresh count, so a correct password sent then is granted.
- R11: During the window, from its second cycle onward, `scan_en_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode_i | input | 1 | Test-mode request from the tester |
| auth_vld_i | input | 1 | Strobe: a password bit is present this cycle |
| auth_bit_i | input | 1 | Serial password bit, most significant first |
| key_iso_o | output | 1 | Isolate the cipher key from the scan chains |
| sens_clr_o | output | 1 | One-cycle clear of key and intermediate registers |
| scan_en_o | output | 1 | Scan shifting permitted |
| full_test_o | output | 1 | 1 = unrestricted scan granted, 0 = restricted or functional |

## Verification
The final password bit and the closing of the window can land on the same clock edge. In that case the completed comparison has to win over the timeout. The bench provokes this by streaming a correct password with no gap, starting in the first window cycle, so the last bit is taken on the window's final cycle; it then expects `full_test_o` to be 1. The same password delayed by a single cycle puts its last bit one edge past the window, and the bench expects restricted mode with `full_test_o` at 0.

// File: rtl/scan_auth_pkg.sv
package scan_auth_pkg;

    typedef enum logic [2:0] {
        ST_FUNC   = 3'd0,
        ST_CLEAR  = 3'd1,
        ST_AUTH   = 3'd2,
        ST_FULL   = 3'd3,
        ST_SECURE = 3'd4
    } auth_state_e;

    typedef struct packed {
        auth_state_e state;
        logic        to_test;
    } fsm_regs_t;

endpackage

// File: rtl/auth_window_timer.sv
module auth_window_timer #(
    parameter int WINDOW = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic first_o,
    output logic expire_o
);
    localparam int TW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [TW-1:0] LAST = TW'(WINDOW - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (!run_i) begin
            r_d.cnt = '0;
        end else if (r_q.cnt != LAST) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign first_o  = run_i && (r_q.cnt == '0);
    assign expire_o = run_i && (r_q.cnt == LAST);

    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= LAST);                                   // R7
    AST_WIN_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_i) |-> (r_q.cnt == '0));                  // R4

endmodule

// File: rtl/auth_key_cmp.sv
module auth_key_cmp #(
    parameter int              KEY_W  = 128,
    parameter logic [KEY_W-1:0] SECRET = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic bit_vld_i,
    input  logic bit_i,
    output logic done_o,
    output logic match_o
);
    localparam int CW = (KEY_W > 1) ? $clog2(KEY_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(KEY_W - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mism;
    } cmp_regs_t;

    cmp_regs_t     r_q, r_d;
    logic [CW-1:0] idx;
    logic          bit_ok;
    logic          take;

    assign idx    = LAST - r_q.cnt;
    assign bit_ok = (bit_i == SECRET[idx]);
    assign take   = run_i && bit_vld_i;

    always_comb begin
        r_d = r_q;
        if (!run_i) begin
            r_d = '0;
        end else if (take) begin
            r_d.mism = r_q.mism | ~bit_ok;
            if (r_q.cnt != LAST) r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done_o  = take && (r_q.cnt == LAST);
    assign match_o = !r_q.mism && bit_ok;

    AST_MISMATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && r_q.mism) |=> r_q.mism);                  // R6

endmodule

// File: rtl/auth_mode_fsm.sv
module auth_mode_fsm
    import scan_auth_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        test_mode_i,
    input  logic        key_done_i,
    input  logic        key_match_i,
    input  logic        win_first_i,
    input  logic        win_expire_i,
    output logic        auth_run_o,
    output logic        clear_o,
    output logic        iso_o,
    output logic        scan_o,
    output logic        full_o
);
    fsm_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_FUNC: begin
                if (test_mode_i) begin
                    r_d.state   = ST_CLEAR;
                    r_d.to_test = 1'b1;
                end
            end
            ST_CLEAR: begin
                r_d.state   = (r_q.to_test && test_mode_i) ? ST_AUTH : ST_FUNC;
                r_d.to_test = 1'b0;
            end
            ST_AUTH: begin
                if (!test_mode_i) begin
                    r_d.state   = ST_CLEAR;
                    r_d.to_test = 1'b0;
                end else if (key_done_i) begin
                    r_d.state = key_match_i ? ST_FULL : ST_SECURE;
                end else if (win_expire_i) begin
                    r_d.state = ST_SECURE;
                end
            end
            ST_FULL, ST_SECURE: begin
                if (!test_mode_i) begin
                    r_d.state   = ST_CLEAR;
                    r_d.to_test = 1'b0;
                end
            end
            default: begin
                r_d.state   = ST_CLEAR;
                r_d.to_test = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ST_FUNC;
            r_q.to_test <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign auth_run_o = (r_q.state == ST_AUTH);
    assign clear_o    = (r_q.state == ST_CLEAR);
    assign full_o     = (r_q.state == ST_FULL);
    assign iso_o      = (r_q.state != ST_FULL) &&
                        (test_mode_i || (r_q.state != ST_FUNC));
    assign scan_o     = (r_q.state == ST_FULL) || (r_q.state == ST_SECURE) ||
                        ((r_q.state == ST_AUTH) && !win_first_i);

    AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_FUNC && test_mode_i) |=> clear_o);          // R2
    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |=> !clear_o);                                      // R2
    AST_GRANT_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_o) |-> $past(key_done_i && key_match_i));        // R5
    AST_SECURE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SECURE && test_mode_i) |=> (r_q.state == ST_SECURE)); // R8
    AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.state == ST_FULL || r_q.state == ST_SECURE) && !test_mode_i)
        |=> clear_o);                                               // R9

endmodule

// File: rtl/scan_auth_ctrl.sv
module scan_auth_ctrl #(
    parameter int               KEY_W  = 128,
    parameter int               WINDOW = 128,
    parameter logic [KEY_W-1:0] SECRET = 128'h3C5A_96E1_0F2D_B478_C3A5_691E_F0D2_4B87
) (
    input  logic clk,
    input  logic rst_n,
    input  logic test_mode_i,
    input  logic auth_vld_i,
    input  logic auth_bit_i,
    output logic key_iso_o,
    output logic sens_clr_o,
    output logic scan_en_o,
    output logic full_test_o
);
    logic auth_run;
    logic key_done;
    logic key_match;
    logic win_first;
    logic win_expire;

    auth_window_timer #(.WINDOW(WINDOW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (auth_run),
        .first_o  (win_first),
        .expire_o (win_expire)
    );

    auth_key_cmp #(.KEY_W(KEY_W), .SECRET(SECRET)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (auth_run),
        .bit_vld_i (auth_vld_i),
        .bit_i     (auth_bit_i),
        .done_o    (key_done),
        .match_o   (key_match)
    );

    auth_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .test_mode_i  (test_mode_i),
        .key_done_i   (key_done),
        .key_match_i  (key_match),
        .win_first_i  (win_first),
        .win_expire_i (win_expire),
        .auth_run_o   (auth_run),
        .clear_o      (sens_clr_o),
        .iso_o        (key_iso_o),
        .scan_o       (scan_en_o),
        .full_o       (full_test_o)
    );

    AST_CLEAR_NO_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        sens_clr_o |-> (!scan_en_o && key_iso_o));                  // R2
    AST_TEST_ISOLATES: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode_i && !full_test_o) |-> key_iso_o);               // R3

endmodule

// File: tb/sim_scan_auth_ctrl.sv
module sim_scan_auth_ctrl;
    localparam logic [127:0] PWD = 128'hA5C3_0F96_1E2D_B478_5A3C_E1F0_692D_4B87;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic test_mode = 1'b0;
    logic vld = 1'b0;
    logic bitv = 1'b0;
    logic iso, clr, scan, full;
    int   total = 0;
    int   bad = 0;

    always #2 clk = ~clk;

    scan_auth_ctrl #(.KEY_W(128), .WINDOW(128), .SECRET(PWD)) u0 (
        .clk(clk), .rst_n(rst_n), .test_mode_i(test_mode),
        .auth_vld_i(vld), .auth_bit_i(bitv),
        .key_iso_o(iso), .sens_clr_o(clr), .scan_en_o(scan), .full_test_o(full)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%b exp=%b", tag, act, exp);
        end
    endtask

    // Enter test mode and reach the first window cycle.
    task automatic enter();
        test_mode = 1'b1;
        #0.5;
        chk("R3 iso on rise", iso, 1'b1);
        step();
        chk("R2 clear pulse", clr, 1'b1);
        chk("R2 scan off in clear", scan, 1'b0);
        step();
        chk("R2 clear single", clr, 1'b0);
        chk("R2 scan off first window cycle", scan, 1'b0);
        chk("R3 iso in window", iso, 1'b1);
    endtask

    task automatic send(input logic [127:0] k);
        for (int i = 0; i < 128; i++) begin
            vld  = 1'b1;
            bitv = k[127-i];
            if (i == 1) chk("R11 scan on in window", scan, 1'b1);
            step();
        end
        vld  = 1'b0;
        bitv = 1'b0;
    endtask

    task automatic leave();
        test_mode = 1'b0;
        step();
        chk("R9 exit clear", clr, 1'b1);
        chk("R9 iso during exit clear", iso, 1'b1);
        step();
        chk("R9 clear single", clr, 1'b0);
        chk("R9 func iso", iso, 1'b0);
        chk("R9 func scan", scan, 1'b0);
        chk("R9 func full", full, 1'b0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
        chk("R1 iso", iso, 1'b0);
        chk("R1 clr", clr, 1'b0);
        chk("R1 scan", scan, 1'b0);
        chk("R1 full", full, 1'b0);
    endtask

    // Gapless stream: last bit coincides with the final window cycle.
    task automatic t_good_key();
        enter();
        send(PWD);
        chk("R5 R7 full granted", full, 1'b1);
        chk("R5 iso released", iso, 1'b0);
        chk("R5 scan on", scan, 1'b1);
        leave();
    endtask

    task automatic t_wrong_then_lock();
        enter();
        send(PWD ^ 128'h1);
        chk("R6 full denied", full, 1'b0);
        chk("R6 iso kept", iso, 1'b1);
        chk("R6 scan on", scan, 1'b1);
        send(PWD);
        chk("R8 lock holds", full, 1'b0);
        chk("R8 iso holds", iso, 1'b1);
        leave();
    endtask

    task automatic t_late_key();
        enter();
        step();
        send(PWD);
        chk("R7 late key denied", full, 1'b0);
        chk("R7 iso kept", iso, 1'b1);
        leave();
    endtask

    task automatic t_abort();
        enter();
        for (int i = 0; i < 40; i++) begin
            vld  = 1'b1;
            bitv = PWD[127-i];
            step();
        end
        vld = 1'b0;
        leave();
        enter();
        send(PWD);
        chk("R10 fresh session granted", full, 1'b1);
        leave();
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_good_key();
                t_wrong_then_lock();
                t_late_key();
                t_abort();
            end
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: act=timeout exp=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule